// File: doc/BRIEF.md
# Serial Flash Status Register and Write Guard

This block keeps the status byte of a serial NOR flash and decides which modifying commands may run. The command decoder upstream hands it one-cycle strobes: latch set, latch clear, status write with a data byte, page program, sector erase and bulk erase. With them come the index of the addressed sector and the level of the active-low write-protect pin. An operation timer elsewhere returns a completion pulse when a launched operation has finished.

Each strobe gets one registered verdict: accepted or rejected. An accepted status write, program or erase also pulses a busy-start output and raises the in-progress bit. The in-progress bit stays up until the completion pulse arrives. That pulse also drops the write-enable latch. The protected area is a top-down range of sectors set by the block-protect field. The field holds 3 or 4 bits, chosen by a parameter. The stored bits are plain registers that reset to zero.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset the status byte reads 0x00.
- R2: With bit 0 clear, a latch-set strobe is accepted and sets status bit 1. A latch-clear strobe is accepted and clears it. Neither pulses busy_start.
- R3: A status write, page program, sector erase or bulk erase issued while status bit 1 is 0 is rejected. The status byte is unchanged and busy_start stays low.
- R4: An accepted status write loads bit 7 from data bit 7 and the protect field (bits 2 upward, NUM_BP wide) from the same data bits. Bit 6 and any unused field bit read 0. Data bits 1:0 are ignored, so a status write can never set bit 1.
- R5: When bit 7 is 1 and wp_n is 0, a status write is rejected and bits 7:2 keep their value. With wp_n at 1 the same write is accepted.
- R6: Let P be a nonzero protect value and S = 2^SECT_W sectors. For P not all ones, the top min(2^(P-1), S) sectors are protected. For P all ones, every sector is protected. Page program and sector erase to a protected sector are rejected.
- R7: Bulk erase is accepted only when the protect field is 0.
- R8: An accepted status write, program or erase sets bit 0 and pulses busy_start in the same cycle. A later op_done clears bit 0 and bit 1 together.
- R9: While bit 0 is 1, every strobe is rejected. Without op_done, bits 7:1 stay unchanged.
- R10: op_done while bit 0 is 0 changes nothing.
- R11: Each strobe gives exactly one accept or reject pulse, one cycle long, in the cycle after the strobe. A cycle with no strobe gives neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wren | input | 1 | Write-enable latch set strobe |
| cmd_wrdi | input | 1 | Write-enable latch clear strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Data byte for status write |
| cmd_pp | input | 1 | Page program strobe |
| cmd_se | input | 1 | Sector erase strobe |
| cmd_be | input | 1 | Bulk erase strobe |
| sector_idx | input | SECT_W | Target sector of program or sector erase |
| wp_n | input | 1 | Write-protect pin level, active low |
| op_done | input | 1 | Completion pulse from the operation timer |
| status | output | 8 | Status byte: 7 lock, 5:2 protect, 1 latch, 0 in progress |
| cmd_accept | output | 1 | Strobe of the previous cycle was executed |
| cmd_reject | output | 1 | Strobe of the previous cycle was refused |
| busy_start | output | 1 | Timed operation launched in the previous cycle |

## Verification
Every result of the block sits one register away from its cause. The status byte, the accept or reject pulse and busy_start all change at the first rising edge that samples a strobe or op_done. The bench drives each strobe on a falling edge and removes it on the next falling edge. It reads all outputs at that second falling edge, half a period after the edge that captured them. The protected-sector sweep therefore checks each of the 16 protect codes against all 16 sectors with no timing slack to misjudge.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
   localparam int unsigned ST_WIP  = 0;
   localparam int unsigned ST_WEL  = 1;
   localparam int unsigned ST_BP0  = 2;
   localparam int unsigned ST_LOCK = 7;
   localparam int unsigned ST_W    = 8;

   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_LSET  = 3'd1,
      OP_LCLR  = 3'd2,
      OP_SWR   = 3'd3,
      OP_PROG  = 3'd4,
      OP_SERA  = 3'd5,
      OP_BERA  = 3'd6
   } op_e;

   function automatic logic op_is_timed(op_e op);
      return (op == OP_SWR) || (op == OP_PROG) || (op == OP_SERA) || (op == OP_BERA);
   endfunction
endpackage

// File: rtl/fsr_cmd_encode.sv
module fsr_cmd_encode
   import flash_sr_pkg::*;
(
   input  logic cmd_wren,
   input  logic cmd_wrdi,
   input  logic cmd_wrsr,
   input  logic cmd_pp,
   input  logic cmd_se,
   input  logic cmd_be,
   output op_e  op
);
   always_comb begin
      if (cmd_wren)      op = OP_LSET;
      else if (cmd_wrdi) op = OP_LCLR;
      else if (cmd_wrsr) op = OP_SWR;
      else if (cmd_pp)   op = OP_PROG;
      else if (cmd_se)   op = OP_SERA;
      else if (cmd_be)   op = OP_BERA;
      else               op = OP_IDLE;
   end
endmodule

// File: rtl/fsr_protect_map.sv
module fsr_protect_map #(
   parameter int unsigned NUM_BP = 4,
   parameter int unsigned SECT_W = 8
) (
   input  logic [NUM_BP-1:0] bp,
   input  logic [SECT_W-1:0] sector,
   output logic              prot,
   output logic              bp_zero
);
   localparam logic [SECT_W-1:0] ONE_S = SECT_W'(1);

   logic [SECT_W-1:0] low_mask;
   int                span;

   always_comb begin
      bp_zero  = (bp == '0);
      span     = int'(bp) - 1;
      low_mask = '0;
      prot     = 1'b0;
      if (bp_zero) begin
         prot = 1'b0;
      end else if (&bp) begin
         prot = 1'b1;
      end else if (span >= int'(SECT_W)) begin
         prot = 1'b1;
      end else begin
         low_mask = (ONE_S << span) - ONE_S;
         prot     = &(sector | low_mask);
      end
   end
endmodule

// File: rtl/fsr_cmd_gate.sv
module fsr_cmd_gate
   import flash_sr_pkg::*;
(
   input  op_e  op,
   input  logic wip,
   input  logic wel,
   input  logic lock,
   input  logic wp_n,
   input  logic sect_prot,
   input  logic bp_zero,
   output logic accept,
   output logic reject,
   output logic launch
);
   logic allowed;

   always_comb begin
      unique case (op)
         OP_LSET, OP_LCLR: allowed = 1'b1;
         OP_SWR:           allowed = wel && !(lock && !wp_n);
         OP_PROG, OP_SERA: allowed = wel && !sect_prot;
         OP_BERA:          allowed = wel && bp_zero;
         default:          allowed = 1'b0;
      endcase
      accept = (op != OP_IDLE) && !wip && allowed;
      reject = (op != OP_IDLE) && !accept;
      launch = accept && op_is_timed(op);
   end
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
   import flash_sr_pkg::*;
#(
   parameter int unsigned NUM_BP = 4,
   parameter int unsigned SECT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wren,
   input  logic              cmd_wrdi,
   input  logic              cmd_wrsr,
   input  logic [7:0]        wrsr_data,
   input  logic              cmd_pp,
   input  logic              cmd_se,
   input  logic              cmd_be,
   input  logic [SECT_W-1:0] sector_idx,
   input  logic              wp_n,
   input  logic              op_done,
   output logic [7:0]        status,
   output logic              cmd_accept,
   output logic              cmd_reject,
   output logic              busy_start
);
   localparam int unsigned FIELD_W = 4;

   if (NUM_BP != 3 && NUM_BP != 4) begin : g_bad_bp
      $error("flash_sr_guard: NUM_BP must be 3 or 4");
   end
   if (SECT_W < 1 || SECT_W > 24) begin : g_bad_sect
      $error("flash_sr_guard: SECT_W out of range");
   end

   op_e               op;
   logic              accept, reject, launch;
   logic              sect_prot, bp_zero;
   logic              wip_q, wel_q, lock_q;
   logic [NUM_BP-1:0] bp_q;
   logic [FIELD_W-1:0] bp_field;
   logic              unused_wrsr_bits;

   assign unused_wrsr_bits = ^wrsr_data;

   fsr_cmd_encode i_enc (
      .cmd_wren (cmd_wren),
      .cmd_wrdi (cmd_wrdi),
      .cmd_wrsr (cmd_wrsr),
      .cmd_pp   (cmd_pp),
      .cmd_se   (cmd_se),
      .cmd_be   (cmd_be),
      .op       (op)
   );

   fsr_protect_map #(.NUM_BP(NUM_BP), .SECT_W(SECT_W)) i_map (
      .bp      (bp_q),
      .sector  (sector_idx),
      .prot    (sect_prot),
      .bp_zero (bp_zero)
   );

   fsr_cmd_gate i_gate (
      .op        (op),
      .wip       (wip_q),
      .wel       (wel_q),
      .lock      (lock_q),
      .wp_n      (wp_n),
      .sect_prot (sect_prot),
      .bp_zero   (bp_zero),
      .accept    (accept),
      .reject    (reject),
      .launch    (launch)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wip_q      <= 1'b0;
         wel_q      <= 1'b0;
         lock_q     <= 1'b0;
         bp_q       <= '0;
         cmd_accept <= 1'b0;
         cmd_reject <= 1'b0;
         busy_start <= 1'b0;
      end else begin
         cmd_accept <= accept;
         cmd_reject <= reject;
         busy_start <= launch;
         if (op_done && wip_q) begin
            wip_q <= 1'b0;
            wel_q <= 1'b0;
         end else if (accept) begin
            unique case (op)
               OP_LSET: wel_q <= 1'b1;
               OP_LCLR: wel_q <= 1'b0;
               OP_SWR: begin
                  bp_q   <= wrsr_data[ST_BP0 +: NUM_BP];
                  lock_q <= wrsr_data[ST_LOCK];
                  wip_q  <= 1'b1;
               end
               OP_PROG, OP_SERA, OP_BERA: wip_q <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   if (NUM_BP == FIELD_W) begin : g_field_full
      assign bp_field = bp_q;
   end else begin : g_field_pad
      assign bp_field = {{(FIELD_W - NUM_BP){1'b0}}, bp_q};
   end

   always_comb begin
      status          = '0;
      status[ST_WIP]  = wip_q;
      status[ST_WEL]  = wel_q;
      status[ST_BP0 +: FIELD_W] = bp_field;
      status[ST_LOCK] = lock_q;
   end
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wren,
   input logic       cmd_wrdi,
   input logic       cmd_wrsr,
   input logic       cmd_pp,
   input logic       cmd_se,
   input logic       cmd_be,
   input logic       wp_n,
   input logic       op_done,
   input logic [7:0] status,
   input logic       cmd_accept,
   input logic       cmd_reject,
   input logic       busy_start
);
   logic any_cmd, timed_cmd;
   assign any_cmd   = cmd_wren | cmd_wrdi | cmd_wrsr | cmd_pp | cmd_se | cmd_be;
   assign timed_cmd = cmd_wrsr | cmd_pp | cmd_se | cmd_be;

   p_single_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be}));

   p_verdict_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_accept && cmd_reject));

   p_verdict_due_r11: assert property (@(posedge clk) disable iff (!rst_n)
      any_cmd |=> (cmd_accept || cmd_reject));

   p_no_wel_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (timed_cmd && !status[1]) |=> (cmd_reject && !busy_start));

   p_wel_not_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wrsr && !status[1]) |=> !status[1]);

   p_hw_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wrsr && status[7] && !wp_n && !status[0]) |=> (cmd_reject && $stable(status[7:2])));

   p_be_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_be && (status[5:2] != 4'd0)) |=> !busy_start);

   p_launch_sets_wip_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_start |-> (status[0] && cmd_accept));

   p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done && status[0]) |=> (!status[0] && !status[1]));

   p_busy_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (any_cmd && status[0]) |=> cmd_reject);

   p_busy_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (status[0] && !op_done) |=> $stable(status[7:1]));
endmodule

bind flash_sr_guard fsr_checker i_fsr_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_wren   (cmd_wren),
   .cmd_wrdi   (cmd_wrdi),
   .cmd_wrsr   (cmd_wrsr),
   .cmd_pp     (cmd_pp),
   .cmd_se     (cmd_se),
   .cmd_be     (cmd_be),
   .wp_n       (wp_n),
   .op_done    (op_done),
   .status     (status),
   .cmd_accept (cmd_accept),
   .cmd_reject (cmd_reject),
   .busy_start (busy_start)
);

// File: tb/test_flash_sr_guard.sv
module test_flash_sr_guard;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 4;
   localparam int NSECT = 1 << SW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_pp = 0, cmd_se = 0, cmd_be = 0;
   logic [7:0]    wrsr_data = '0;
   logic [SW-1:0] sector_idx = '0;
   logic          wp_n = 1'b1;
   logic          op_done = 1'b0;
   logic [7:0]    status;
   logic          cmd_accept, cmd_reject, busy_start;

   int n_chk = 0;
   int n_fail = 0;

   logic       m_wip = 0, m_wel = 0, m_lock = 0;
   logic [3:0] m_bp = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_sr_guard #(.NUM_BP(4), .SECT_W(SW)) i_flash_sr_guard (
      .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
      .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_pp(cmd_pp), .cmd_se(cmd_se),
      .cmd_be(cmd_be), .sector_idx(sector_idx), .wp_n(wp_n), .op_done(op_done),
      .status(status), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
      .busy_start(busy_start)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_status();
      return {m_lock, 1'b0, m_bp, m_wel, m_wip};
   endfunction

   function automatic logic is_prot(logic [3:0] bp, int sec);
      int cnt;
      if (bp == 0) return 1'b0;
      if (bp == 4'hF) return 1'b1;
      cnt = 1 << (int'(bp) - 1);
      if (cnt >= NSECT) return 1'b1;
      return sec >= (NSECT - cnt);
   endfunction

   // kind: 1 latch set, 2 latch clear, 3 status write, 4 program, 5 sector erase, 6 bulk erase
   task automatic run_cmd(int kind, logic [7:0] data, int sec, logic wp, string req);
      logic acc;
      wp_n = wp;
      if (m_wip) acc = 0;
      else begin
         case (kind)
            1, 2:    acc = 1;
            3:       acc = m_wel && !(m_lock && !wp);
            4, 5:    acc = m_wel && !is_prot(m_bp, sec);
            default: acc = m_wel && (m_bp == 0);
         endcase
      end
      @(negedge clk);
      wrsr_data  = data;
      sector_idx = SW'(sec);
      cmd_wren = (kind == 1); cmd_wrdi = (kind == 2); cmd_wrsr = (kind == 3);
      cmd_pp   = (kind == 4); cmd_se   = (kind == 5); cmd_be   = (kind == 6);
      @(negedge clk);
      cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_pp = 0; cmd_se = 0; cmd_be = 0;
      if (acc) begin
         case (kind)
            1: m_wel = 1;
            2: m_wel = 0;
            3: begin m_bp = data[5:2]; m_lock = data[7]; m_wip = 1; end
            default: m_wip = 1;
         endcase
      end
      check({req, " accept"}, cmd_accept, acc);
      check({req, " reject"}, cmd_reject, !acc);
      check({req, " busy_start"}, busy_start, acc && kind >= 3);
      check({req, " status"}, status, exp_status());
   endtask

   task automatic finish_op(string req);
      @(negedge clk);
      op_done = 1;
      @(negedge clk);
      op_done = 0;
      if (m_wip) begin m_wip = 0; m_wel = 0; end
      check({req, " status after done"}, status, exp_status());
      check({req, " no verdict on done"}, cmd_accept | cmd_reject, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 reset status", status, 8'h00);
      check("R11 idle no verdict", cmd_accept | cmd_reject | busy_start, 0);

      run_cmd(1, 8'h00, 0, 1, "R2 latch set");
      run_cmd(2, 8'h00, 0, 1, "R2 latch clear");
      run_cmd(3, 8'h9C, 0, 1, "R3 swr without latch");
      run_cmd(4, 8'h00, 0, 1, "R3 prog without latch");
      run_cmd(5, 8'h00, 3, 1, "R3 sera without latch");
      run_cmd(6, 8'h00, 0, 1, "R3 bera without latch");

      run_cmd(1, 8'h00, 0, 1, "R8 latch set");
      run_cmd(4, 8'h00, 5, 1, "R8 prog launch");
      run_cmd(1, 8'h00, 0, 1, "R9 set while busy");
      run_cmd(2, 8'h00, 0, 1, "R9 clear while busy");
      run_cmd(3, 8'hBC, 0, 1, "R9 swr while busy");
      run_cmd(6, 8'h00, 0, 1, "R9 bera while busy");
      finish_op("R8 completion");
      finish_op("R10 stray done");

      for (int bp = 0; bp < 16; bp++) begin
         run_cmd(1, 8'h00, 0, 1, "R4 latch set");
         run_cmd(3, 8'((bp << 2) | 8'h43), 0, 1, "R4 swr protect field");
         finish_op("R4 swr done");
         for (int sec = 0; sec < NSECT; sec++) begin
            run_cmd(1, 8'h00, 0, 1, "R6 latch set");
            run_cmd((sec % 2 == 0) ? 4 : 5, 8'h00, sec, 1, "R6 region check");
            if (m_wip) finish_op("R6 done");
         end
         run_cmd(1, 8'h00, 0, 1, "R7 latch set");
         run_cmd(6, 8'h00, 0, 1, "R7 bulk erase guard");
         if (m_wip) finish_op("R7 done");
      end

      run_cmd(1, 8'h00, 0, 1, "R5 latch set");
      run_cmd(3, 8'h88, 0, 1, "R5 set lock bit");
      finish_op("R5 done");
      run_cmd(1, 8'h00, 0, 0, "R5 latch set pin low");
      run_cmd(3, 8'h00, 0, 0, "R5 swr locked");
      run_cmd(3, 8'h00, 0, 1, "R5 swr pin high");
      finish_op("R5 unlock done");

      @(negedge clk);
      check("R11 idle after traffic", cmd_accept | cmd_reject | busy_start, 0);
      check("R10 final status", status, exp_status());

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule